// File: doc/BRIEF.md
# Supervisor Counter Inhibit Alias

This block holds the machine-level counter inhibit register and exposes a masked supervisor alias of it at CSR number 0x120. The counter-enable mask chosen by machine mode decides which bits supervisor software may touch. Where a counter's enable bit is set, the alias bit reads and writes the matching machine inhibit bit. Where the enable bit is clear, the alias bit reads as zero and ignores writes. Bit 1, the real-time timer slot, is hardwired to zero in both views.

Access to the alias is guarded by a delegation enable and by the privilege mode. With delegation off, every access raises illegal-instruction. With delegation on, guest (virtualized) accesses raise virtual-instruction. Machine mode also reaches the full register directly at CSR number 0x320, independent of the mask. The registered inhibit vector drives the counters. Supervisor software can find out which counters it owns by writing all ones to the alias and reading the value back.

Top module: `cnt_inhibit_alias`

## Requirements
- R1: A read of CSR 0x120 from S or M mode (virtualization flag 0, delegation enable 1) returns the machine inhibit register ANDed with the counter-enable mask, with bit 1 zero, in the same cycle, and raises no flag.
- R2: An accepted write to CSR 0x120 makes the machine register equal (old AND NOT enable) OR (write data AND enable), with bit 1 zero; non-delegated bits keep their value.
- R3: With delegation enable 0, any read or write of CSR 0x120 from any mode raises the illegal flag (virtual flag 0), returns read data 0 and changes no state.
- R4: With delegation enable 1 and virtualization flag 1 (VS or VU), any access to CSR 0x120 raises the virtual flag (illegal flag 0), returns read data 0 and changes no state.
- R5: With delegation enable 1, a non-virtualized access to CSR 0x120 from U mode (privilege code 2'b00) or the reserved code 2'b10 raises the illegal flag and changes no state. Privilege codes are U=2'b00, S=2'b01, M=2'b11.
- R6: Bit 1 reads as zero through both addresses and is never set in the inhibit vector, whatever is written.
- R7: An access to CSR 0x320 in M mode (privilege 2'b11, virtualization flag 0) reads the full machine register, and a write there replaces every bit except bit 1, regardless of the enable mask and the delegation enable.
- R8: An access to CSR 0x320 from any mode other than non-virtualized M raises the illegal flag and changes no state.
- R9: After writing all ones to CSR 0x120, a read of CSR 0x120 returns exactly the counter-enable mask with bit 1 cleared.
- R10: Reset clears every inhibit bit.
- R11: The inhibit vector output equals the machine register and reflects an accepted write on the next rising clock edge, not before.
- R12: An access to any other CSR number raises no flag, returns read data 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR number of the current access |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| priv | input | 2 | Privilege mode: 00 U, 01 S, 11 M |
| virt | input | 1 | Virtualization flag (guest modes) |
| deleg_en | input | 1 | Counter delegation enable |
| cnt_enable | input | 32 | Machine counter-enable mask, one bit per counter |
| csr_rdata | output | 32 | Read data, combinational |
| illegal_o | output | 1 | Illegal-instruction flag, combinational |
| virtual_o | output | 1 | Virtual-instruction flag, combinational |
| inhibit_o | output | 32 | Registered per-counter inhibit vector |

## Verification
Read data and both trap flags depend only on the current inputs and the stored register, so they are due in the same cycle as the access. The bench drives each access on a falling edge and samples them one nanosecond later. The inhibit vector is due one rising edge after an accepted write. The bench compares it at the following falling edge, and it also compares the vector before that edge to show it has not yet moved. Rejected and ignored accesses are confirmed by reading the vector and by reading the register back through M mode at 0x320.

// File: rtl/cia_pkg.sv
package cia_pkg;
    localparam logic [11:0] ADDR_S_ALIAS = 12'h120;
    localparam logic [11:0] ADDR_M_FULL  = 12'h320;

    typedef enum logic [1:0] {
        PRV_U   = 2'b00,
        PRV_S   = 2'b01,
        PRV_RSV = 2'b10,
        PRV_M   = 2'b11
    } prv_e;
endpackage

// File: rtl/cia_decode.sv
module cia_decode
    import cia_pkg::*;
(
    input  logic [11:0] addr,
    input  logic        rd,
    input  logic        wr,
    input  logic [1:0]  priv,
    input  logic        virt,
    input  logic        deleg_en,
    output logic        s_ok,
    output logic        m_ok,
    output logic        illegal,
    output logic        virtual_trap
);
    logic access;
    logic hit_s;
    logic hit_m;
    logic sup_or_mach;
    logic mach;

    always_comb begin
        access      = rd | wr;
        hit_s       = access && (addr == ADDR_S_ALIAS);
        hit_m       = access && (addr == ADDR_M_FULL);
        sup_or_mach = !virt && ((priv == PRV_S) || (priv == PRV_M));
        mach        = !virt && (priv == PRV_M);

        illegal      = 1'b0;
        virtual_trap = 1'b0;
        s_ok         = 1'b0;
        m_ok         = 1'b0;

        if (hit_s) begin
            if (!deleg_en)        illegal      = 1'b1;
            else if (virt)        virtual_trap = 1'b1;
            else if (!sup_or_mach) illegal     = 1'b1;
            else                  s_ok         = 1'b1;
        end
        if (hit_m) begin
            if (mach) m_ok    = 1'b1;
            else      illegal = 1'b1;
        end
    end
endmodule

// File: rtl/cia_view.sv
module cia_view #(
    parameter int CTR_W     = 32,
    parameter int TIMER_IDX = 1
) (
    input  logic [CTR_W-1:0] minh_q,
    input  logic [CTR_W-1:0] enable,
    input  logic [CTR_W-1:0] wdata,
    output logic [CTR_W-1:0] s_rview,
    output logic [CTR_W-1:0] s_merge,
    output logic [CTR_W-1:0] m_clean
);
    for (genvar b = 0; b < CTR_W; b++) begin : g_bit
        if (b == TIMER_IDX) begin : g_timer
            assign s_rview[b] = 1'b0;
            assign s_merge[b] = 1'b0;
            assign m_clean[b] = 1'b0;
        end else begin : g_ctr
            assign s_rview[b] = minh_q[b] & enable[b];
            assign s_merge[b] = enable[b] ? wdata[b] : minh_q[b];
            assign m_clean[b] = wdata[b];
        end
    end
endmodule

// File: rtl/cnt_inhibit_alias.sv
module cnt_inhibit_alias
    import cia_pkg::*;
#(
    parameter int CTR_W     = 32,
    parameter int TIMER_IDX = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [11:0]      csr_addr,
    input  logic             csr_rd,
    input  logic             csr_wr,
    input  logic [CTR_W-1:0] csr_wdata,
    input  logic [1:0]       priv,
    input  logic             virt,
    input  logic             deleg_en,
    input  logic [CTR_W-1:0] cnt_enable,
    output logic [CTR_W-1:0] csr_rdata,
    output logic             illegal_o,
    output logic             virtual_o,
    output logic [CTR_W-1:0] inhibit_o
);
    localparam logic [CTR_W-1:0] TIMER_MASK = CTR_W'(1) << TIMER_IDX;

    typedef struct packed {
        logic [CTR_W-1:0] minh;
    } state_t;

    state_t state_d, state_q;

    logic             s_ok, m_ok, trap_ill, trap_virt;
    logic [CTR_W-1:0] s_rview, s_merge, m_clean;

    cia_decode i_decode (
        .addr         (csr_addr),
        .rd           (csr_rd),
        .wr           (csr_wr),
        .priv         (priv),
        .virt         (virt),
        .deleg_en     (deleg_en),
        .s_ok         (s_ok),
        .m_ok         (m_ok),
        .illegal      (trap_ill),
        .virtual_trap (trap_virt)
    );

    cia_view #(.CTR_W(CTR_W), .TIMER_IDX(TIMER_IDX)) i_view (
        .minh_q  (state_q.minh),
        .enable  (cnt_enable),
        .wdata   (csr_wdata),
        .s_rview (s_rview),
        .s_merge (s_merge),
        .m_clean (m_clean)
    );

    always_comb begin
        state_d = state_q;
        if (csr_wr && s_ok) state_d.minh = s_merge;
        if (csr_wr && m_ok) state_d.minh = m_clean;

        csr_rdata = '0;
        if (csr_rd && s_ok) csr_rdata = s_rview;
        if (csr_rd && m_ok) csr_rdata = state_q.minh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign illegal_o = trap_ill;
    assign virtual_o = trap_virt;
    assign inhibit_o = state_q.minh;

    // Flags are mutually exclusive (R3, R4)
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal_o && virtual_o));

    // Timer slot never set (R6)
    assert_timer_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_o & TIMER_MASK) == '0);

    // Alias read never exposes non-delegated bits (R1)
    assert_read_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && csr_addr == ADDR_S_ALIAS) |-> ((csr_rdata & ~cnt_enable) == '0));

    // Alias write leaves non-delegated bits alone (R2)
    assert_nodeleg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_addr == ADDR_S_ALIAS && !m_ok) |=>
        ((inhibit_o & ~$past(cnt_enable)) == ($past(inhibit_o) & ~$past(cnt_enable))));

    // Trapped write changes nothing (R3, R4, R5, R8)
    assert_trap_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && (illegal_o || virtual_o)) |=> $stable(inhibit_o));

    // Trapped access returns zero data (R4)
    assert_trap_zero_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o || virtual_o) |-> (csr_rdata == '0));
endmodule

// File: tb/test_cnt_inhibit_alias.sv
module test_cnt_inhibit_alias;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_rd = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [1:0]  priv = 2'b11;
    logic        virt = 1'b0;
    logic        deleg_en = 1'b0;
    logic [31:0] cnt_enable = '0;
    logic [31:0] csr_rdata;
    logic        illegal_o;
    logic        virtual_o;
    logic [31:0] inhibit_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_m = '0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    cnt_inhibit_alias i_cnt_inhibit_alias (
        .clk, .rst_n, .csr_addr, .csr_rd, .csr_wr, .csr_wdata,
        .priv, .virt, .deleg_en, .cnt_enable,
        .csr_rdata, .illegal_o, .virtual_o, .inhibit_o
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at falling edge, sample combinational results 1 ns later,
    // then sample the inhibit vector at the following falling edge.
    task automatic access(input string req, input logic [11:0] a, input logic rd, input logic wr,
                          input logic [31:0] wd, input logic [1:0] p, input logic v,
                          input logic [31:0] exp_rd, input logic exp_ill, input logic exp_virt,
                          input logic [31:0] exp_next);
        @(negedge clk);
        csr_addr = a; csr_rd = rd; csr_wr = wr; csr_wdata = wd; priv = p; virt = v;
        #1;
        check({req, " rdata"}, csr_rdata, exp_rd);
        check({req, " flags"}, {30'd0, illegal_o, virtual_o}, {30'd0, exp_ill, exp_virt});
        check({req, " no early update R11"}, inhibit_o, exp_m);
        @(negedge clk);
        csr_rd = 1'b0; csr_wr = 1'b0;
        exp_m = exp_next;
        check({req, " inhibit after edge"}, inhibit_o, exp_m);
    endtask

    task automatic m_write(input string req, input logic [31:0] wd);
        access(req, 12'h320, 1'b0, 1'b1, wd, 2'b11, 1'b0, 32'h0, 1'b0, 1'b0, wd & ~32'h2);
    endtask

    task automatic m_readback(input string req);
        access(req, 12'h320, 1'b1, 1'b0, 32'h0, 2'b11, 1'b0, exp_m, 1'b0, 1'b0, exp_m);
    endtask

    task automatic t_reset;
        check("R10 reset inhibit", inhibit_o, 32'h0);
        m_readback("R10 reset readback");
    endtask

    task automatic t_mfull;
        deleg_en = 1'b0; cnt_enable = 32'h0;
        m_write("R7 full write", 32'hFFFF_FFFF);
        check("R6 timer bit", inhibit_o & 32'h2, 32'h0);
        m_readback("R7 full read");
        m_write("R7 pattern", 32'hA5A5_5A5A);
        m_readback("R7 pattern read");
    endtask

    task automatic t_sread;
        deleg_en = 1'b1; cnt_enable = 32'h0F0F_00FF;
        access("R1 S read", 12'h120, 1'b1, 1'b0, 0, 2'b01, 1'b0,
               exp_m & cnt_enable & ~32'h2, 1'b0, 1'b0, exp_m);
        access("R1 M read alias", 12'h120, 1'b1, 1'b0, 0, 2'b11, 1'b0,
               exp_m & cnt_enable & ~32'h2, 1'b0, 1'b0, exp_m);
    endtask

    task automatic t_swrite;
        logic [31:0] en;
        en = 32'h0F0F_00FF; deleg_en = 1'b1; cnt_enable = en;
        access("R2 S write zeros", 12'h120, 1'b0, 1'b1, 32'h0, 2'b01, 1'b0, 0, 1'b0, 1'b0,
               (exp_m & ~en) & ~32'h2);
        access("R2 S write ones", 12'h120, 1'b0, 1'b1, 32'hFFFF_FFFF, 2'b01, 1'b0, 0, 1'b0, 1'b0,
               ((exp_m & ~en) | en) & ~32'h2);
        m_readback("R2 readback");
    endtask

    task automatic t_discover;
        deleg_en = 1'b1; cnt_enable = 32'h8000_00C7;
        m_write("R9 clear", 32'h0);
        access("R9 write ones", 12'h120, 1'b0, 1'b1, 32'hFFFF_FFFF, 2'b01, 1'b0, 0, 1'b0, 1'b0,
               32'h8000_00C5);
        access("R9 discover", 12'h120, 1'b1, 1'b0, 0, 2'b01, 1'b0, 32'h8000_00C5, 1'b0, 1'b0, exp_m);
        check("R6 timer via alias", inhibit_o & 32'h2, 32'h0);
    endtask

    task automatic t_traps;
        m_write("setup", 32'h1234_5670);
        deleg_en = 1'b0; cnt_enable = 32'hFFFF_FFFF;
        access("R3 deleg off S", 12'h120, 1'b1, 1'b1, 32'h0, 2'b01, 1'b0, 0, 1'b1, 1'b0, exp_m);
        access("R3 deleg off M", 12'h120, 1'b1, 1'b1, 32'h0, 2'b11, 1'b0, 0, 1'b1, 1'b0, exp_m);
        access("R3 deleg off VS", 12'h120, 1'b0, 1'b1, 32'h0, 2'b01, 1'b1, 0, 1'b1, 1'b0, exp_m);
        deleg_en = 1'b1;
        access("R4 VS", 12'h120, 1'b1, 1'b1, 32'h0, 2'b01, 1'b1, 0, 1'b0, 1'b1, exp_m);
        access("R4 VU", 12'h120, 1'b0, 1'b1, 32'h0, 2'b00, 1'b1, 0, 1'b0, 1'b1, exp_m);
        access("R5 U", 12'h120, 1'b1, 1'b1, 32'h0, 2'b00, 1'b0, 0, 1'b1, 1'b0, exp_m);
        access("R5 reserved", 12'h120, 1'b0, 1'b1, 32'h0, 2'b10, 1'b0, 0, 1'b1, 1'b0, exp_m);
        access("R8 S to M reg", 12'h320, 1'b1, 1'b1, 32'h0, 2'b01, 1'b0, 0, 1'b1, 1'b0, exp_m);
        access("R8 virt M reg", 12'h320, 1'b1, 1'b1, 32'h0, 2'b11, 1'b1, 0, 1'b1, 1'b0, exp_m);
        access("R12 other addr", 12'h121, 1'b1, 1'b1, 32'h0, 2'b11, 1'b0, 0, 1'b0, 1'b0, exp_m);
        m_readback("R3 R4 R5 R8 R12 state kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mfull();
        t_sread();
        t_swrite();
        t_discover();
        t_traps();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule